// File: doc/BRIEF.md
# Multi-Character Holding Register Port

This block sits between a host bus and the transmit and receive FIFOs of a serial port. It turns each read of the receive holding register into pop requests toward the receive FIFO, and each write of the transmit holding register into push requests toward the transmit FIFO. When the FIFOs are on and the line runs plain 8-bit asynchronous framing, a 32-bit access moves four characters at once. An 8-bit access always moves a single character. When the FIFOs are off, 9-bit characters are selected, or the line runs one of the bus-style line modes, every access moves one character.

The FIFOs report how many characters they hold (receive) and how many slots are free (transmit), and they present their four oldest receive characters. The block grants at most what is available. It packs the read word with the oldest character in the lowest byte and fills unused bytes with zero. It flags any access that asked for more than was available. Two ready flags compare the FIFO levels against a per-direction ready mode, so the host waits until a whole multi-character access can succeed.

Top module: `mdata_hold_port`

## Requirements
- R1: In multi-character mode a 32-bit read pops min(4, rx_level) characters. The registered read word carries the oldest character in bits 7:0, the next in 15:8, then 23:16 and 31:24.
- R2: In multi-character mode a 32-bit write pushes min(4, tx_free) characters, taken from wdata with bits 7:0 first and bits 31:24 last.
- R3: An 8-bit access moves exactly one character when one is available. A byte read returns it in bits 7:0 with the upper bits zero.
- R4: Multi-character mode holds only when fifo_en is 1, nine_bit is 0 and line_mode is 0. line_mode values 1, 2 and 3 name the two bus-master/slave line modes and the network line mode.
- R5: In single-character mode a 32-bit access moves at most one character.
- R6: tx_rdy is 1 exactly when tx_free is at least the needed count. The needed count comes from fifo_mode bits 1:0: 0 means 1, 1 means 2, 2 means 4 and 3 means 1. When fifo_en is 0 the needed count is 1.
- R7: rx_rdy is 1 exactly when rx_level is at least the needed count. The needed count comes from fifo_mode bits 5:4 with the same encoding as R6.
- R8: A read that gets fewer characters than it asked for zero-fills the missing bytes and raises rx_ptr_err for the one cycle after the access. A write that gets fewer raises tx_ptr_err the same way.
- R9: After reset, rdata is 0 and both error pulses are 0. No push or pop is requested without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| nine_bit | input | 1 | 9-bit character mode selected |
| line_mode | input | 2 | 0 plain async; 1, 2, 3 bus-style line modes |
| fifo_mode | input | 8 | Ready modes: tx at bits 1:0, rx at bits 5:4 |
| wr_en | input | 1 | Write strobe to the transmit holding register |
| rd_en | input | 1 | Read strobe from the receive holding register |
| acc_word | input | 1 | 1 for a 32-bit access, 0 for an 8-bit access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tx_push_cnt | output | 3 | Characters to push this cycle |
| tx_push_data | output | 32 | Characters to push, first in bits 7:0 |
| tx_free | input | LVL_W | Free transmit FIFO slots |
| rx_pop_cnt | output | 3 | Characters to pop this cycle |
| rx_head | input | 32 | Four oldest receive characters, oldest in bits 7:0 |
| rx_level | input | LVL_W | Characters stored in the receive FIFO |
| tx_rdy | output | 1 | Transmit ready per ready mode |
| rx_rdy | output | 1 | Receive ready per ready mode |
| tx_ptr_err | output | 1 | Short write pulse |
| rx_ptr_err | output | 1 | Short read pulse |

## Verification
Random accesses mix byte and word sizes over all four line modes, both nine_bit and fifo_en values, and FIFO levels from 0 to 8. Word accesses at levels of 4 or more show that the mode choice alone sets the count to four or one. Levels from 1 to 3 separate correct clipping and zero fill from a design that always moves the requested count. Directed cases at level 0 and at exactly the ready thresholds tell the error pulse and each ready-mode encoding apart, including the reserved value 3.

// File: rtl/mdata_hold_port.sv
module mdata_hold_port #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             nine_bit,
  input  logic [1:0]       line_mode,
  input  logic [7:0]       fifo_mode,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             acc_word,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [2:0]       tx_push_cnt,
  output logic [31:0]      tx_push_data,
  input  logic [LVL_W-1:0] tx_free,
  output logic [2:0]       rx_pop_cnt,
  input  logic [31:0]      rx_head,
  input  logic [LVL_W-1:0] rx_level,
  output logic             tx_rdy,
  output logic             rx_rdy,
  output logic             tx_ptr_err,
  output logic             rx_ptr_err
);

  function automatic logic [2:0] need_of(input logic [1:0] m);
    case (m)
      2'd1:    need_of = 3'd2;
      2'd2:    need_of = 3'd4;
      default: need_of = 3'd1;
    endcase
  endfunction

  function automatic logic [2:0] clip(input logic [2:0] want, input logic [LVL_W-1:0] avail);
    clip = (avail < LVL_W'(want)) ? 3'(avail) : want;
  endfunction

  logic       multi;
  logic [2:0] want;
  logic [2:0] tx_grant, rx_grant;
  logic [31:0] rd_pack;

  assign multi    = fifo_en && !nine_bit && (line_mode == 2'd0);
  assign want     = (acc_word && multi) ? 3'd4 : 3'd1;
  assign tx_grant = clip(want, tx_free);
  assign rx_grant = clip(want, rx_level);

  assign tx_push_cnt  = wr_en ? tx_grant : 3'd0;
  assign tx_push_data = wdata;
  assign rx_pop_cnt   = rd_en ? rx_grant : 3'd0;

  for (genvar i = 0; i < 4; i++) begin : g_pack
    assign rd_pack[8*i +: 8] = (rx_grant > 3'(i)) ? rx_head[8*i +: 8] : 8'h00;
  end

  assign tx_rdy = tx_free  >= LVL_W'(need_of(fifo_en ? fifo_mode[1:0] : 2'd0));
  assign rx_rdy = rx_level >= LVL_W'(need_of(fifo_en ? fifo_mode[5:4] : 2'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata      <= '0;
      tx_ptr_err <= 1'b0;
      rx_ptr_err <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_pack;
      tx_ptr_err <= wr_en && (tx_grant != want);
      rx_ptr_err <= rd_en && (rx_grant != want);
    end
  end

endmodule

// File: rtl/mdata_hold_port_chk.sv
module mdata_hold_port_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             nine_bit,
  input logic [1:0]       line_mode,
  input logic             wr_en,
  input logic             rd_en,
  input logic             acc_word,
  input logic [2:0]       tx_push_cnt,
  input logic [LVL_W-1:0] tx_free,
  input logic [2:0]       rx_pop_cnt,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_rdy,
  input logic             rx_ptr_err
);
  logic single;
  assign single = nine_bit || (line_mode != 2'd0) || !fifo_en;

  // R1
  word_read_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && acc_word && !single && rx_level >= LVL_W'(4)) |-> rx_pop_cnt == 3'd4);

  // R2
  word_write_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_word && !single && tx_free >= LVL_W'(4)) |-> tx_push_cnt == 3'd4);

  // R3
  byte_read_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !acc_word && rx_level != '0) |-> rx_pop_cnt == 3'd1);

  // R5
  single_mode_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single && rd_en && rx_level != '0) |-> rx_pop_cnt == 3'd1);

  // R8
  short_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_level == '0) |=> rx_ptr_err);

  // R9
  idle_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rx_pop_cnt == 3'd0);

  // R6
  rdy_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rdy |-> tx_free != '0);
endmodule

bind mdata_hold_port mdata_hold_port_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .nine_bit(nine_bit),
  .line_mode(line_mode), .wr_en(wr_en), .rd_en(rd_en), .acc_word(acc_word),
  .tx_push_cnt(tx_push_cnt), .tx_free(tx_free), .rx_pop_cnt(rx_pop_cnt),
  .rx_level(rx_level), .tx_rdy(tx_rdy), .rx_ptr_err(rx_ptr_err)
);

// File: tb/tb_mdata_hold_port.sv
module tb_mdata_hold_port;
  localparam int LVL_W = 6;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, nine_bit = 0, wr_en = 0, rd_en = 0, acc_word = 0;
  logic [1:0] line_mode = 0;
  logic [7:0] fifo_mode = 0;
  logic [31:0] wdata = 0, rx_head = 0, rdata, tx_push_data;
  logic [2:0] tx_push_cnt, rx_pop_cnt;
  logic [LVL_W-1:0] tx_free = 0, rx_level = 0;
  logic tx_rdy, rx_rdy, tx_ptr_err, rx_ptr_err;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdata_hold_port #(.LVL_W(LVL_W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int need(input logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
  endfunction

  function automatic int grant(input int want, input int avail);
    return (avail < want) ? avail : want;
  endfunction

  function automatic logic [31:0] pack(input logic [31:0] h, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (i < n) r[8*i +: 8] = h[8*i +: 8];
    return r;
  endfunction

  task automatic access(input bit fe, nb, input logic [1:0] lm, input logic [7:0] fm,
                        input bit wr, rd, word, input int free, lvl);
    bit multi;
    int want, tg, rg;
    logic [31:0] exp_rd;
    fifo_en = fe; nine_bit = nb; line_mode = lm; fifo_mode = fm;
    wr_en = wr; rd_en = rd; acc_word = word;
    wdata = $urandom; rx_head = $urandom;
    tx_free = LVL_W'(free); rx_level = LVL_W'(lvl);
    multi = fe && !nb && lm == 0;
    want = (word && multi) ? 4 : 1;
    tg = grant(want, free); rg = grant(want, lvl);
    exp_rd = pack(rx_head, rg);
    #1;
    chk(multi ? (word ? "R1/R2" : "R3") : "R5", {29'b0, rx_pop_cnt}, rd ? rg : 0);
    chk(multi ? (word ? "R2" : "R3") : "R4", {29'b0, tx_push_cnt}, wr ? tg : 0);
    if (wr) chk("R2", tx_push_data, wdata);
    chk("R6", {31'b0, tx_rdy}, (free >= need(fe ? fm[1:0] : 2'd0)) ? 1 : 0);
    chk("R7", {31'b0, rx_rdy}, (lvl >= need(fe ? fm[5:4] : 2'd0)) ? 1 : 0);
    @(negedge clk);
    if (rd) chk(word ? "R1" : "R3", rdata, exp_rd);
    chk("R8", {31'b0, rx_ptr_err}, (rd && rg < want) ? 1 : 0);
    chk("R8", {31'b0, tx_ptr_err}, (wr && tg < want) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9", rdata, 0);
    chk("R9", {30'b0, tx_ptr_err, rx_ptr_err}, 0);
    chk("R9", {26'b0, tx_push_cnt, rx_pop_cnt}, 0);
    // directed: word access, multi mode, full level
    access(1, 0, 0, 8'h00, 1, 1, 1, 8, 8);
    // R4: each line mode / nine_bit / fifo disabled forces single
    access(1, 0, 1, 8'h00, 1, 1, 1, 8, 8);
    access(1, 0, 2, 8'h00, 1, 1, 1, 8, 8);
    access(1, 0, 3, 8'h00, 1, 1, 1, 8, 8);
    access(1, 1, 0, 8'h00, 1, 1, 1, 8, 8);
    access(0, 0, 0, 8'h22, 1, 1, 1, 8, 8);
    // R8: short and empty
    access(1, 0, 0, 8'h00, 1, 1, 1, 2, 3);
    access(1, 0, 0, 8'h00, 1, 1, 0, 0, 0);
    // R6/R7: thresholds at exact boundaries, reserved value 3
    for (int m = 0; m < 4; m++) begin
      access(1, 0, 0, {2'b0, 2'(m), 2'b0, 2'(m)}, 0, 0, 0, need(2'(m)), need(2'(m)));
      access(1, 0, 0, {2'b0, 2'(m), 2'b0, 2'(m)}, 0, 0, 0, need(2'(m)) - 1, need(2'(m)) - 1);
    end
    for (int k = 0; k < 400; k++) begin
      access(($urandom % 5) != 0, ($urandom % 5) == 0,
             (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'd0,
             8'($urandom), $urandom % 2, $urandom % 2, $urandom % 2,
             $urandom % 9, $urandom % 9);
    end
    wr_en = 0; rd_en = 0;
    @(negedge clk);
    chk("R9", {26'b0, tx_push_cnt, rx_pop_cnt}, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule